// File: doc/BRIEF.md
# Per-Core Power Zone Sequencer

This block takes a secondary processor core's power zone up or down for hotplug. It owns one control word per core and one reset-hold bit per core. It steps the control bits in a fixed order. Between some steps it waits for status bits that the zone reports back, and each wait has a timeout.

A command is made of three inputs sampled together: a core index, a direction (up or down) and a one-cycle start strobe. While the block works on the command, `busy_o` is high. When the command ends, `done_o` pulses for one cycle. If a status wait runs out of time, a sticky error flag is set. Each control step is one register write in one clock cycle, and the next step starts only in the cycle after that write.

A power-up is needed only when the zone reports that it is held in reset. When the zone is already powered, a power-up only releases the core's reset-hold bit. Core 0 is the boot core, and a power-down aimed at it is refused.

Top module: `zone_pwr_seq`

## Requirements
- R1: After reset, every control word equals `CTRL_INIT`, the reset-hold bits are 1 for every core except core 0 (which is 0), and `busy_o`, `done_o` and `err_o` are 0.
- R2: The control bit positions are: clock enable bit 0, reset release bit 1, memory power bit 4, auxiliary power bit 5, isolation bit 6, manual mode bit 7. Power-up runs these steps in order:
  - set isolation, set manual, set auxiliary, set memory;
  - wait for memory status = 1, then set clock;
  - wait for gate status = 1, then clear isolation, set reset release;
  - clear the core's hold bit.
- R3: The first power-up write clears control bits 7:0 before it sets isolation. Bits above 7 keep their values.
- R4: Power-down runs these steps in order:
  - set manual, clear reset release, clear clock, set isolation, clear memory;
  - wait for memory status = 0, then clear auxiliary;
  - wait for gate status = 0, then set the core's hold bit.
- R5: While a wait's status does not match the expected level, no control word changes. The sequence goes on once the status matches.
- R6: If a status still does not match after `TIMEOUT_CYC` polling cycles and one final check, the command ends:
  - `err_o` is set and stays set;
  - `done_o` pulses;
  - the control words are left as they were.
- R7: A power-up goes through the power steps only when the core's `rst_stat_i` bit is 1. Otherwise the command changes no control bit and only clears the core's hold bit.
- R8: A power-down for core 0 changes no control word and no hold bit, pulses `done_o` and leaves `err_o` at 0.
- R9: There is one hold bit per core, indexed by core number. A command touches only the selected core's hold bit.
- R10: A start strobe that arrives while `busy_o` is high is ignored.
- R11: An accepted start clears `err_o`.
- R12: `busy_o` is high from the cycle after an accepted start until `done_o` pulses. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a command |
| cmd_up_i | input | 1 | 1 = power up, 0 = power down |
| core_i | input | IDX_W | Target core index |
| rst_stat_i | input | NCORES | Per-core status: zone held in reset |
| mem_stat_i | input | NCORES | Per-core status: memory powered |
| pg_stat_i | input | NCORES | Per-core status: power gate on |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse when a command ends |
| err_o | output | 1 | Sticky timeout error |
| zone_ctrl_o | output | NCORES*CTRL_W | Control words, core c at bits c*CTRL_W upward |
| hold_o | output | NCORES | Per-core reset-hold bits |

## Verification
The assertions assume a few things about the inputs:
- the status inputs of the selected core change only in response to that core's control word;
- the start strobe and its command fields are stable at the sampling edge.

The bench meets these assumptions in two ways. It drives commands only at falling edges. It feeds the status inputs from a small zone model that follows the control bits with a three-cycle delay. The model can also hold a core's memory status low on purpose, and the bench uses this to force a timeout. The assertions on stability during waits and outside commands hold for any status input. The hold-bit assertion for core 0 assumes that only power-down commands ever set hold bits.

// File: rtl/zps_pkg.sv
package zps_pkg;

   typedef enum logic [2:0] {
      OP_SET,
      OP_CLR,
      OP_SETLOW,
      OP_WAIT,
      OP_HOLD,
      OP_END
   } op_e;

   typedef struct packed {
      op_e        op;
      logic [2:0] bidx;
      logic       lvl;
      logic       on_pg;
   } step_t;

   localparam logic [2:0] B_CLK = 3'd0;
   localparam logic [2:0] B_RST = 3'd1;
   localparam logic [2:0] B_MEM = 3'd4;
   localparam logic [2:0] B_AUX = 3'd5;
   localparam logic [2:0] B_ISO = 3'd6;
   localparam logic [2:0] B_MAN = 3'd7;

   localparam int unsigned STEP_W = 4;
   localparam logic [STEP_W-1:0] UP_SKIP_IDX = 4'd9;

   function automatic step_t mk(op_e op, logic [2:0] b, logic l, logic p);
      step_t s;
      s.op    = op;
      s.bidx  = b;
      s.lvl   = l;
      s.on_pg = p;
      return s;
   endfunction

endpackage

// File: rtl/zps_step_rom.sv
module zps_step_rom
   import zps_pkg::*;
(
   input  logic              up,
   input  logic [STEP_W-1:0] idx,
   output step_t             step
);
   // Step table. Power-up index UP_SKIP_IDX must stay the hold-release step.
   always_comb begin
      step = mk(OP_END, 3'd0, 1'b0, 1'b0);
      if (up) begin
         case (idx)
            4'd0: step = mk(OP_SETLOW, B_ISO, 1'b0, 1'b0);
            4'd1: step = mk(OP_SET,    B_MAN, 1'b0, 1'b0);
            4'd2: step = mk(OP_SET,    B_AUX, 1'b0, 1'b0);
            4'd3: step = mk(OP_SET,    B_MEM, 1'b0, 1'b0);
            4'd4: step = mk(OP_WAIT,   3'd0,  1'b1, 1'b0);
            4'd5: step = mk(OP_SET,    B_CLK, 1'b0, 1'b0);
            4'd6: step = mk(OP_WAIT,   3'd0,  1'b1, 1'b1);
            4'd7: step = mk(OP_CLR,    B_ISO, 1'b0, 1'b0);
            4'd8: step = mk(OP_SET,    B_RST, 1'b0, 1'b0);
            4'd9: step = mk(OP_HOLD,   3'd0,  1'b0, 1'b0);
            default: ;
         endcase
      end else begin
         case (idx)
            4'd0: step = mk(OP_SET,    B_MAN, 1'b0, 1'b0);
            4'd1: step = mk(OP_CLR,    B_RST, 1'b0, 1'b0);
            4'd2: step = mk(OP_CLR,    B_CLK, 1'b0, 1'b0);
            4'd3: step = mk(OP_SET,    B_ISO, 1'b0, 1'b0);
            4'd4: step = mk(OP_CLR,    B_MEM, 1'b0, 1'b0);
            4'd5: step = mk(OP_WAIT,   3'd0,  1'b0, 1'b0);
            4'd6: step = mk(OP_CLR,    B_AUX, 1'b0, 1'b0);
            4'd7: step = mk(OP_WAIT,   3'd0,  1'b0, 1'b1);
            4'd8: step = mk(OP_HOLD,   3'd0,  1'b1, 1'b0);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/zps_wait_timer.sv
module zps_wait_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

   initial begin
      if (LIMIT < 1) $error("LIMIT must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clr)             cnt_q <= '0;
      else if (tick && !expired) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LIM);

   // R6: the poll counter never runs past its limit
   p_cnt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM);
endmodule

// File: rtl/zps_ctrl_bank.sv
module zps_ctrl_bank
   import zps_pkg::*;
#(
   parameter int unsigned NCORES    = 4,
   parameter int unsigned CTRL_W    = 32,
   parameter logic [CTRL_W-1:0] CTRL_INIT = '0,
   localparam int unsigned IDX_W    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IDX_W-1:0]         sel,
   input  logic                     wr_en,
   input  op_e                      wr_op,
   input  logic [2:0]               wr_bit,
   input  logic                     hold_en,
   input  logic                     hold_val,
   output logic [NCORES*CTRL_W-1:0] ctrl_flat,
   output logic [NCORES-1:0]        hold
);
   localparam logic [CTRL_W-1:0] LOW_MASK = CTRL_W'(8'hFF);

   logic [CTRL_W-1:0] bmask;
   assign bmask = CTRL_W'(1) << wr_bit;

   for (genvar g = 0; g < NCORES; g++) begin : g_core
      localparam logic HOLD_RST = (g != 0);
      logic [CTRL_W-1:0] ctrl_q;
      logic              hold_q;
      logic              hit;
      assign hit = (sel == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
            hold_q <= HOLD_RST;
         end else if (hit) begin
            if (wr_en) begin
               case (wr_op)
                  OP_SET:    ctrl_q <= ctrl_q | bmask;
                  OP_CLR:    ctrl_q <= ctrl_q & ~bmask;
                  OP_SETLOW: ctrl_q <= (ctrl_q & ~LOW_MASK) | bmask;
                  default:   ;
               endcase
            end
            if (hold_en) hold_q <= hold_val;
         end
      end

      assign ctrl_flat[g*CTRL_W +: CTRL_W] = ctrl_q;
      assign hold[g] = hold_q;
   end

   // R8: boot core's hold bit is never raised once low
   p_core0_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hold[0] |=> !hold[0]);
endmodule

// File: rtl/zone_pwr_seq.sv
module zone_pwr_seq
   import zps_pkg::*;
#(
   parameter int unsigned NCORES      = 4,
   parameter int unsigned CTRL_W      = 32,
   parameter logic [CTRL_W-1:0] CTRL_INIT = '0,
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned TIMEOUT_MS  = 500,
   parameter int unsigned TIMEOUT_CYC = CLK_HZ / 1000 * TIMEOUT_MS,
   localparam int unsigned IDX_W      = (NCORES > 1) ? $clog2(NCORES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     cmd_up_i,
   input  logic [IDX_W-1:0]         core_i,
   input  logic [NCORES-1:0]        rst_stat_i,
   input  logic [NCORES-1:0]        mem_stat_i,
   input  logic [NCORES-1:0]        pg_stat_i,
   output logic                     busy_o,
   output logic                     done_o,
   output logic                     err_o,
   output logic [NCORES*CTRL_W-1:0] zone_ctrl_o,
   output logic [NCORES-1:0]        hold_o
);
   initial begin
      if (NCORES < 2)                 $error("NCORES must be at least 2");
      if ((1 << IDX_W) != NCORES)     $error("NCORES must be a power of two");
      if (CTRL_W < 8)                 $error("CTRL_W must hold the 8 control bits");
      if (TIMEOUT_CYC < 1)            $error("TIMEOUT_CYC must be at least 1");
   end

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_LAST} state_e;

   state_e            state_q;
   logic [IDX_W-1:0]  core_q;
   logic              up_q;
   logic [STEP_W-1:0] idx_q;
   logic              err_q;
   logic              done_q;

   step_t step;
   logic  stat_sel;
   logic  stat_hit;
   logic  expired;
   logic  in_wait;

   zps_step_rom u_rom (
      .up   (up_q),
      .idx  (idx_q),
      .step (step)
   );

   assign stat_sel = step.on_pg ? pg_stat_i[core_q] : mem_stat_i[core_q];
   assign stat_hit = (stat_sel == step.lvl);
   assign in_wait  = (state_q == S_RUN) && (step.op == OP_WAIT);

   logic wr_en;
   logic hold_en;
   assign wr_en   = (state_q == S_RUN) &&
                    (step.op == OP_SET || step.op == OP_CLR || step.op == OP_SETLOW);
   assign hold_en = (state_q == S_RUN) && (step.op == OP_HOLD);

   zps_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!in_wait || stat_hit),
      .tick    (in_wait && !stat_hit),
      .expired (expired)
   );

   zps_ctrl_bank #(
      .NCORES    (NCORES),
      .CTRL_W    (CTRL_W),
      .CTRL_INIT (CTRL_INIT)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (core_q),
      .wr_en     (wr_en),
      .wr_op     (step.op),
      .wr_bit    (step.bidx),
      .hold_en   (hold_en),
      .hold_val  (step.lvl),
      .ctrl_flat (zone_ctrl_o),
      .hold      (hold_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         core_q  <= '0;
         up_q    <= 1'b0;
         idx_q   <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  err_q <= 1'b0;
                  if (!cmd_up_i && core_i == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     core_q  <= core_i;
                     up_q    <= cmd_up_i;
                     idx_q   <= (cmd_up_i && !rst_stat_i[core_i]) ? UP_SKIP_IDX : '0;
                     state_q <= S_RUN;
                  end
               end
            end
            S_RUN: begin
               case (step.op)
                  OP_END: begin
                     state_q <= S_IDLE;
                     done_q  <= 1'b1;
                  end
                  OP_WAIT: begin
                     if (stat_hit)     idx_q   <= idx_q + 1'b1;
                     else if (expired) state_q <= S_LAST;
                  end
                  default: idx_q <= idx_q + 1'b1;
               endcase
            end
            S_LAST: begin
               if (stat_hit) begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= S_RUN;
               end else begin
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != S_IDLE);
   assign done_o = done_q;
   assign err_o  = err_q;

   // R8: no control change outside a running command
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE) |=> $stable(zone_ctrl_o));
   // R5: control words frozen while a status wait is unmatched
   p_wait_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && !stat_hit) |=> $stable(zone_ctrl_o));
   // R12: completion never overlaps busy
   p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R11: an accepted start leaves the error flag clear
   p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && start_i) |=> !err_o);
   // R6: error flag holds until a new command is accepted
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !(state_q == S_IDLE && start_i)) |=> err_o);
endmodule

// File: tb/zone_pwr_seq_bench.sv
module zone_pwr_seq_bench;
   localparam int NC = 4;
   localparam int CW = 32;
   localparam int TO = 20;
   localparam logic [31:0] INIT = 32'h5A00_000C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic cmd_up = 1'b0;
   logic [1:0] core = '0;
   logic [NC-1:0] rst_stat, mem_stat, pg_stat, hold;
   logic busy, done, err;
   logic [NC*CW-1:0] ctrl;

   always #5 clk = ~clk;

   zone_pwr_seq #(
      .NCORES(NC), .CTRL_W(CW), .CTRL_INIT(INIT), .TIMEOUT_CYC(TO)
   ) u_zone_pwr_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_up_i(cmd_up),
      .core_i(core), .rst_stat_i(rst_stat), .mem_stat_i(mem_stat),
      .pg_stat_i(pg_stat), .busy_o(busy), .done_o(done), .err_o(err),
      .zone_ctrl_o(ctrl), .hold_o(hold)
   );

   // zone model: status follows control bits three cycles later
   logic [2:0] mem_d [NC];
   logic [2:0] pg_d [NC];
   logic [NC-1:0] stuck = '0;
   logic [NC-1:0] force_on = '0;

   always @(posedge clk) begin
      for (int c = 0; c < NC; c++) begin
         if (!rst_n) begin
            mem_d[c] <= '0;
            pg_d[c]  <= '0;
         end else begin
            mem_d[c] <= {mem_d[c][1:0], ctrl[c*CW+4]};
            pg_d[c]  <= {pg_d[c][1:0], ctrl[c*CW] & ctrl[c*CW+5]};
         end
      end
   end

   always_comb begin
      for (int c = 0; c < NC; c++) begin
         mem_stat[c] = !stuck[c] && mem_d[c][2];
         pg_stat[c]  = pg_d[c][2];
         rst_stat[c] = !force_on[c] && !ctrl[c*CW+1];
      end
   end

   // change log of control words
   int log_n = 0;
   int log_c [64];
   logic [31:0] log_w [64];
   logic [31:0] prev [NC];

   always @(negedge clk) begin
      for (int c = 0; c < NC; c++) begin
         if (rst_n && ctrl[c*CW +: CW] !== prev[c]) begin
            if (log_n < 64) begin
               log_c[log_n] = c;
               log_w[log_n] = ctrl[c*CW +: CW];
            end
            log_n++;
         end
         prev[c] = ctrl[c*CW +: CW];
      end
   end

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] word(int c);
      return ctrl[c*CW +: CW];
   endfunction

   // expected change list, built from the requirement step order
   int exp_n;
   int exp_c [64];
   logic [31:0] exp_w [64];
   logic [31:0] cur;

   function automatic void emit(int c, logic [31:0] nw);
      if (nw !== cur) begin
         exp_c[exp_n] = c;
         exp_w[exp_n] = nw;
         exp_n++;
      end
      cur = nw;
   endfunction

   task automatic expect_up(int c, logic [31:0] w0, int upto);
      exp_n = 0;
      cur = w0;
      if (upto > 0) emit(c, (cur & ~32'hFF) | 32'h40);
      if (upto > 1) emit(c, cur | 32'h80);
      if (upto > 2) emit(c, cur | 32'h20);
      if (upto > 3) emit(c, cur | 32'h10);
      if (upto > 4) emit(c, cur | 32'h01);
      if (upto > 5) emit(c, cur & ~32'h40);
      if (upto > 6) emit(c, cur | 32'h02);
   endtask

   task automatic expect_down(int c, logic [31:0] w0);
      exp_n = 0;
      cur = w0;
      emit(c, cur | 32'h80);
      emit(c, cur & ~32'h02);
      emit(c, cur & ~32'h01);
      emit(c, cur | 32'h40);
      emit(c, cur & ~32'h10);
      emit(c, cur & ~32'h20);
   endtask

   task automatic compare_log(string req);
      chk(log_n == exp_n, req, "change count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++)
         chk(log_c[i] == exp_c[i] && log_w[i] == exp_w[i], req, "step word",
             {log_c[i][31:0], log_w[i]}, {exp_c[i][31:0], exp_w[i]});
   endtask

   task automatic issue(int c, bit up);
      @(negedge clk);
      log_n = 0;
      core = c[1:0];
      cmd_up = up;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(string req);
      bit seen = 0;
      for (int i = 0; i < 400; i++) begin
         if (done) begin
            seen = 1;
            break;
         end
         @(negedge clk);
      end
      chk(seen, req, "done pulse", seen, 1);
      @(negedge clk);
      chk(!done && !busy, "R12", "done single cycle, idle after", {done, busy}, 0);
   endtask

   task automatic t_reset;
      chk(!busy && !done && !err, "R1", "flags after reset", {busy, done, err}, 0);
      chk(hold == 4'b1110, "R1", "hold bits after reset", hold, 4'b1110);
      for (int c = 0; c < NC; c++)
         chk(word(c) == INIT, "R1", "control word after reset", word(c), INIT);
   endtask

   task automatic t_power_up;
      logic [31:0] w0 = word(1);
      expect_up(1, w0, 7);
      issue(1, 1);
      chk(busy, "R12", "busy after start", busy, 1);
      wait_done("R2");
      compare_log("R2");
      chk(log_w[0] == ((INIT & ~32'hFF) | 32'h40), "R3", "first write clears low byte",
          log_w[0], (INIT & ~32'hFF) | 32'h40);
      chk(hold == 4'b1100, "R9", "only core 1 hold released", hold, 4'b1100);
      chk(!err, "R2", "no error", err, 0);
   endtask

   task automatic t_skip;
      force_on[3] = 1'b1;
      issue(3, 1);
      wait_done("R7");
      chk(log_n == 0, "R7", "no control change when already powered", log_n, 0);
      chk(hold == 4'b0100, "R7", "hold released on skip", hold, 4'b0100);
   endtask

   task automatic t_refuse;
      issue(0, 0);
      chk(done, "R8", "refusal completes at once", done, 1);
      wait_done("R8");
      chk(log_n == 0, "R8", "core 0 control untouched", log_n, 0);
      chk(hold == 4'b0100 && !err, "R8", "hold and error unchanged", {hold, err}, 8'b01000);
   endtask

   task automatic t_power_down;
      expect_down(1, word(1));
      issue(1, 0);
      wait_done("R4");
      compare_log("R4");
      chk(hold == 4'b0110, "R4", "core 1 hold set", hold, 4'b0110);
   endtask

   task automatic t_busy_ignore;
      expect_up(1, word(1), 7);
      issue(1, 1);
      repeat (2) @(negedge clk);
      core = 2'd2;
      cmd_up = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R10");
      compare_log("R10");
      chk(word(2) == INIT, "R10", "core 2 untouched", word(2), INIT);
      repeat (4) @(negedge clk);
      chk(!busy && word(2) == INIT, "R10", "no queued command", busy, 0);
   endtask

   task automatic t_timeout;
      logic [31:0] w;
      stuck[2] = 1'b1;
      expect_up(2, INIT, 4);
      issue(2, 1);
      wait_done("R6");
      chk(err, "R6", "timeout error", err, 1);
      chk(log_n == 4, "R5", "stopped at memory wait", log_n, 4);
      compare_log("R6");
      w = word(2);
      repeat (10) @(negedge clk);
      chk(word(2) == w && err, "R6", "control kept, error sticky", {err, word(2)}, {1'b1, w});
      chk(hold[2], "R9", "core 2 hold still set", hold[2], 1);
   endtask

   task automatic t_err_clear;
      logic [31:0] w0;
      stuck[2] = 1'b0;
      w0 = word(2);
      expect_up(2, w0, 7);
      issue(2, 1);
      chk(!err, "R11", "error cleared by start", err, 0);
      wait_done("R11");
      compare_log("R3");
      chk(!err && !hold[2], "R11", "clean power-up", {err, hold[2]}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_power_up();
      t_skip();
      t_refuse();
      t_power_down();
      t_busy_ignore();
      t_timeout();
      t_err_clear();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule